// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This unit sits behind an I2C bit-level receiver that has already turned SCL/SDA activity into event pulses (START, repeated START, STOP) and whole received bytes. After every START or repeated START it examines exactly one received byte, the address byte. It raises a one-cycle match flag when that byte addresses this device. Every other byte in the transfer passes by uncompared.

The unit holds one 8-bit register. The upper seven bits hold the device address, with bit 1 as the address LSB. Bit 0 is a direction-state bit. In 7-bit mode only the seven address bits take part in the compare. In 10-bit mode the whole byte, state bit included, is compared. Hardware sets the state bit on a repeated START that follows a successful match in 10-bit mode, so the first address byte sent after the restart must carry a 1 in its LSB. A STOP clears the state bit. A host port writes the whole register, and the register is read back continuously.

Top module: `slvaddr_match`

## Requirements
- R1: After reset the register readback is 0x00 and the match flag is low.
- R2: A host write (wr_en_i high) loads wr_data_i into the register on the next clock. Bits 7..1 are the address and bit 0 is the state bit.
- R3: In 7-bit mode (mode_ten_i = 0), bits 7..1 of the first byte after a START are compared with register bits 7..1, and byte bit 0 is ignored. On equality match_o is high in the cycle after the byte strobe.
- R4: In 10-bit mode (mode_ten_i = 1), the first byte after a START or repeated START matches only when all eight bits equal the register, state bit included.
- R5: Only the first strobed byte after a START or repeated START is compared. Later bytes, and bytes after a STOP with no new START, never raise match_o.
- R6: A STOP clears register bit 0 on the next clock. This takes priority over a host write in the same cycle, whose bits 7..1 still load.
- R7: A repeated START in 10-bit mode, after a match in the same transfer, sets register bit 0 on the next clock. Without a prior match since the last START, or in 7-bit mode, bit 0 is unchanged.
- R8: A START or repeated START in the same cycle as a byte strobe discards that byte without comparing it. The next strobed byte is then compared.
- R9: match_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START condition pulse |
| rstart_i | input | 1 | Repeated START condition pulse |
| stop_i | input | 1 | STOP condition pulse |
| rx_vld_i | input | 1 | Received-byte strobe |
| rx_data_i | input | 8 | Received byte |
| mode_ten_i | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| wr_en_i | input | 1 | Host register write enable |
| wr_data_i | input | 8 | Host register write data |
| match_o | output | 1 | One-cycle address match pulse |
| reg_o | output | 8 | Register readback |

## Verification
The bench builds the unit with its defaults: a 7-bit address field and the 10-bit variant generated. Both compare paths can therefore be reached from the mode pin in a single run. This covers switching a live register between modes, and the repeated-START set of the state bit followed by an address byte that must carry that bit. The collision cases are driven directly: STOP against a host write, and START against a byte strobe.

// File: rtl/slvaddr_pkg.sv
package slvaddr_pkg;

   typedef enum logic {
      MODE_SEVEN = 1'b0,
      MODE_TEN   = 1'b1
   } addr_mode_e;

   typedef struct packed {
      logic start;
      logic rstart;
      logic stop;
   } bus_evt_t;

   function automatic logic evt_any_start(input bus_evt_t e);
      return e.start | e.rstart;
   endfunction

endpackage

// File: rtl/slvaddr_regfile.sv
module slvaddr_regfile #(
   parameter int ADDR_W = 7,
   localparam int BYTE_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              clr_state,
   input  logic              set_state,
   output logic [BYTE_W-1:0] reg_q
);

   logic [ADDR_W-1:0] addr_q;
   logic              state_q;

   // address field: host write only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (wr_en)
         addr_q <= wr_data[BYTE_W-1:1];
   end

   // state bit: clear beats set beats host write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= 1'b0;
      else if (clr_state)
         state_q <= 1'b0;
      else if (set_state)
         state_q <= 1'b1;
      else if (wr_en)
         state_q <= wr_data[0];
   end

   assign reg_q = {addr_q, state_q};

endmodule

// File: rtl/slvaddr_cmp.sv
module slvaddr_cmp
   import slvaddr_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter bit TEN_BIT_EN = 1'b1,
   localparam int BYTE_W = ADDR_W + 1
) (
   input  logic              mode_ten,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [BYTE_W-1:0] reg_q,
   output logic              hit
);

   logic addr_eq;
   logic lsb_eq;

   assign addr_eq = (rx_byte[BYTE_W-1:1] == reg_q[BYTE_W-1:1]);
   assign lsb_eq  = (rx_byte[0] == reg_q[0]);

   generate
      if (TEN_BIT_EN) begin : g_dual
         addr_mode_e mode;
         assign mode = addr_mode_e'(mode_ten);
         always_comb begin
            unique case (mode)
               MODE_TEN: hit = addr_eq & lsb_eq;
               default:  hit = addr_eq;
            endcase
         end
      end else begin : g_seven_only
         logic unused_mode;
         assign unused_mode = mode_ten ^ lsb_eq;
         assign hit = addr_eq;
      end
   endgenerate

endmodule

// File: rtl/slvaddr_seq.sv
module slvaddr_seq
   import slvaddr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  bus_evt_t evt,
   input  logic     rx_vld,
   input  logic     mode_ten,
   input  logic     hit,
   output logic     cmp_fire,
   output logic     set_state,
   output logic     clr_state
);

   logic armed_q;
   logic seen_q;
   logic any_start;

   assign any_start = evt_any_start(evt);

   // a start in the same cycle as a strobe discards the byte
   assign cmp_fire  = armed_q & rx_vld & ~any_start;
   assign set_state = evt.rstart & mode_ten & seen_q;
   assign clr_state = evt.stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b0;
      else if (any_start)
         armed_q <= 1'b1;
      else if (evt.stop || rx_vld)
         armed_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= 1'b0;
      else if (evt.stop || evt.start)
         seen_q <= 1'b0;
      else if (cmp_fire && hit)
         seen_q <= 1'b1;
   end

endmodule

// File: rtl/slvaddr_match.sv
module slvaddr_match
   import slvaddr_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter bit TEN_BIT_EN = 1'b1,
   localparam int BYTE_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rstart_i,
   input  logic              stop_i,
   input  logic              rx_vld_i,
   input  logic [BYTE_W-1:0] rx_data_i,
   input  logic              mode_ten_i,
   input  logic              wr_en_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   output logic              match_o,
   output logic [BYTE_W-1:0] reg_o
);

   generate
      if (ADDR_W < 1 || ADDR_W > 31) begin : g_bad_width
         $error("slvaddr_match: ADDR_W out of range");
      end
   endgenerate

   bus_evt_t          evt;
   logic              hit;
   logic              cmp_fire;
   logic              set_state;
   logic              clr_state;
   logic              match_q;
   logic [BYTE_W-1:0] reg_q;

   assign evt = '{start: start_i, rstart: rstart_i, stop: stop_i};

   slvaddr_regfile #(.ADDR_W(ADDR_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en_i),
      .wr_data   (wr_data_i),
      .clr_state (clr_state),
      .set_state (set_state),
      .reg_q     (reg_q)
   );

   slvaddr_cmp #(.ADDR_W(ADDR_W), .TEN_BIT_EN(TEN_BIT_EN)) u_cmp (
      .mode_ten (mode_ten_i),
      .rx_byte  (rx_data_i),
      .reg_q    (reg_q),
      .hit      (hit)
   );

   slvaddr_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .rx_vld    (rx_vld_i),
      .mode_ten  (mode_ten_i & TEN_BIT_EN),
      .hit       (hit),
      .cmp_fire  (cmp_fire),
      .set_state (set_state),
      .clr_state (clr_state)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         match_q <= 1'b0;
      else
         match_q <= cmp_fire & hit;
   end

   assign match_o = match_q;
   assign reg_o   = reg_q;

endmodule

// File: rtl/slvaddr_chk.sv
module slvaddr_chk #(
   parameter int ADDR_W     = 7,
   parameter bit TEN_BIT_EN = 1'b1,
   localparam int BYTE_W = ADDR_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              rstart_i,
   input logic              stop_i,
   input logic              rx_vld_i,
   input logic [BYTE_W-1:0] rx_data_i,
   input logic              mode_ten_i,
   input logic              wr_en_i,
   input logic [BYTE_W-1:0] wr_data_i,
   input logic              match_o,
   input logic [BYTE_W-1:0] reg_o
);

   AST_HOST_WR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> reg_o[BYTE_W-1:1] == $past(wr_data_i[BYTE_W-1:1])); // R2

   AST_SEVEN_ADDR_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && !$past(mode_ten_i)) |->
         $past(rx_data_i[BYTE_W-1:1]) == $past(reg_o[BYTE_W-1:1])); // R3

   AST_TEN_FULL_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && $past(mode_ten_i) && TEN_BIT_EN) |->
         $past(rx_data_i) == $past(reg_o)); // R4

   AST_MATCH_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> $past(rx_vld_i)); // R5

   AST_STOP_CLEARS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !reg_o[0]); // R6

   AST_START_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_i || rstart_i) && rx_vld_i) |=> !match_o); // R8

   AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |=> !match_o); // R9

endmodule

bind slvaddr_match slvaddr_chk #(.ADDR_W(ADDR_W), .TEN_BIT_EN(TEN_BIT_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .rstart_i   (rstart_i),
   .stop_i     (stop_i),
   .rx_vld_i   (rx_vld_i),
   .rx_data_i  (rx_data_i),
   .mode_ten_i (mode_ten_i),
   .wr_en_i    (wr_en_i),
   .wr_data_i  (wr_data_i),
   .match_o    (match_o),
   .reg_o      (reg_o)
);

// File: tb/slvaddr_match_tb.sv
module slvaddr_match_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 0, rstart_i = 0, stop_i = 0, rx_vld_i = 0;
   logic [7:0] rx_data_i = '0;
   logic       mode_ten_i = 0;
   logic       wr_en_i = 0;
   logic [7:0] wr_data_i = '0;
   logic       match_o;
   logic [7:0] reg_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   bit    exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   slvaddr_match dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rstart_i(rstart_i),
      .stop_i(stop_i), .rx_vld_i(rx_vld_i), .rx_data_i(rx_data_i),
      .mode_ten_i(mode_ten_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .match_o(match_o), .reg_o(reg_o)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // monitor: one expected match value per driven cycle
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         automatic bit    e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         check(t, {7'd0, match_o}, {7'd0, e});
      end
   end

   // driver: called at a negedge, returns at the next negedge
   task automatic step(input logic s, input logic rs, input logic sp,
                       input logic v, input logic [7:0] d,
                       input logic w, input logic [7:0] wd,
                       input bit em, input string tag);
      start_i = s; rstart_i = rs; stop_i = sp;
      rx_vld_i = v; rx_data_i = d; wr_en_i = w; wr_data_i = wd;
      exp_q.push_back(em);
      tag_q.push_back(tag);
      @(negedge clk);
      start_i = 0; rstart_i = 0; stop_i = 0; rx_vld_i = 0; wr_en_i = 0;
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 8'h00, 0, 8'h00, 0, tag);
   endtask
   task automatic sta();
      step(1, 0, 0, 0, 8'h00, 0, 8'h00, 0, "start");
   endtask
   task automatic rsta(input string tag);
      step(0, 1, 0, 0, 8'h00, 0, 8'h00, 0, tag);
   endtask
   task automatic sto(input string tag);
      step(0, 0, 1, 0, 8'h00, 0, 8'h00, 0, tag);
   endtask
   task automatic rxb(input logic [7:0] d, input bit em, input string tag);
      step(0, 0, 0, 1, d, 0, 8'h00, em, tag);
   endtask
   task automatic wr(input logic [7:0] d, input string tag);
      step(0, 0, 0, 0, 8'h00, 1, d, 0, tag);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset reg", reg_o, 8'h00);
      check("R1 reset match", {7'd0, match_o}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 host write
      wr(8'hA4, "R2 write");
      check("R2 readback", reg_o, 8'hA4);

      // R3 7-bit mode, LSB ignored; R5 second byte not compared
      sto("R5 stop");
      sta();
      rxb(8'hA5, 1, "R3 lsb ignored");
      rxb(8'hA4, 0, "R5 second byte");
      sto("stop");
      sta();
      rxb(8'hA6, 0, "R3 mismatch");
      sta();
      rxb(8'hA4, 1, "R3 exact");
      idle("R9 single pulse");
      sto("stop");
      rxb(8'hA4, 0, "R5 no start");

      // R4 / R7 10-bit mode
      mode_ten_i = 1;
      wr(8'hF0, "wr");
      sta();
      rxb(8'hF1, 0, "R4 state bit differs");
      sta();
      rxb(8'hF0, 1, "R4 full match");
      rsta("R7 restart");
      check("R7 state set", reg_o, 8'hF1);
      rxb(8'hF1, 1, "R4 after restart");
      sto("R6 stop");
      check("R6 stop clears", reg_o, 8'hF0);
      sta();
      rxb(8'h10, 0, "R4 other address");
      rsta("R7 no prior match");
      check("R7 no set without match", reg_o, 8'hF0);
      sto("stop");

      // R7 7-bit mode restart leaves state bit
      mode_ten_i = 0;
      sta();
      rxb(8'hF0, 1, "R3 match");
      rsta("R7 seven restart");
      check("R7 no set in 7-bit", reg_o, 8'hF0);
      sto("stop");

      // R6 stop beats host write on bit 0
      wr(8'hF1, "wr");
      check("R2 state via write", reg_o, 8'hF1);
      step(0, 0, 1, 0, 8'h00, 1, 8'h37, 0, "R6 stop+write");
      check("R6 priority", reg_o, 8'h36);

      // R8 start collides with strobe
      sta();
      step(1, 0, 0, 1, 8'h36, 0, 8'h00, 0, "R8 discarded");
      rxb(8'h37, 1, "R8 rearmed");
      step(0, 1, 0, 1, 8'h36, 0, 8'h00, 0, "R8 restart discard");
      rxb(8'h36, 1, "R8 rearmed restart");
      idle("R9 idle");
      sto("stop");

      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule